// File: doc/BRIEF.md
# 6502-style ALU and flag unit

This unit carries out the 8-bit data operations of a 6502-class processor: add and subtract with carry, the three bitwise operations, plain loads, register compares, the bit-test operation, the four shift and rotate forms, and the undocumented operation that subtracts the operand from the AND of the accumulator and X. For every operation it produces the result, a destination select telling the surrounding sequencer which register (if any) takes the result, and the new status byte with N, V, Z and C updated by the exact formulas of the original processor family. Decimal mode is not supported.

In the same cycle it evaluates a relative branch. From the taken flag, the address that follows the branch operand and the signed displacement it returns the next program counter and the extra cycle count the branch costs. Instruction decode, memory access and addressing-mode sequencing live outside the block. By default, inputs are sampled on a strobe and every output is registered, giving one cycle of latency. A parameter can remove the registers to make the unit purely combinational.

Top module: `nmos_alu_flags`

## Requirements
- R1: ADC (op code 4) gives (A + M + C) mod 256 with destination accumulator (dest code 1). C is set to bit 8 of the 9-bit sum. V is set when A and M have the same sign and the sign of the result differs from it. Z and N follow the result.
- R2: SBC (op code 5) gives (A - M - (1 - C)) mod 256 with destination accumulator. C is set when no borrow occurs. V is bit 7 of (A ^ result) & (A ^ M). Z and N follow the result.
- R3: CMP (op 6) computes A - M and CPX (op 7) computes X - M, both with dest code 0 (no write). AXS (op 13) computes (A & X) - M with dest code 2 (X). All three set Z and N from the low byte and set C when no borrow occurs, and all three leave V unchanged.
- R4: BIT (op 8) has dest code 0. It sets Z when (A & M) is zero, copies M bit 7 into N and M bit 6 into V, and leaves C unchanged.
- R5: LOAD (op 0, result M), AND (op 1), ORA (op 2) and EOR (op 3) write the accumulator and update only N and Z. V and C keep their input values.
- R6: ASL (op 9) and LSR (op 10) shift M and give dest code 3 (operand write-back). The bit shifted out goes to C, and the vacated bit is 0, so LSR always clears N. Z follows the result.
- R7: ROL (op 11) and ROR (op 12) rotate M through carry. The incoming C fills the vacated bit, the bit shifted out becomes the new C, and the dest code is 3.
- R8: Status bit 5 of the output is always 1. Status bits 4..2 (I, D, B) pass from the status input unchanged. The flag positions are C=0, Z=1, V=6, N=7.
- R9: A branch that is not taken costs 0 extra cycles and the next PC equals the address after the operand. A taken branch targets that address plus the sign-extended displacement and costs 1 cycle, or 2 when the target's upper byte differs from the upper byte of the address after the operand.
- R10: Outputs update on the clock edge at which op_valid is high and hold their values otherwise. out_valid is high for exactly that following cycle. Reset gives result 0, dest 0, status 0x20, next PC 0 and penalty 0.
- R11: Reserved op codes 14 and 15 give dest code 0 and leave all of the status input unchanged, except that bit 5 is forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Sample the inputs on this edge |
| op_code | input | 4 | Operation select (codes in R1-R7, R11) |
| acc | input | 8 | Accumulator value |
| xreg | input | 8 | X register value |
| operand | input | 8 | Memory or immediate operand |
| status_in | input | 8 | Current status byte |
| br_taken | input | 1 | Branch condition met |
| br_pc | input | 16 | Address following the branch operand |
| br_disp | input | 8 | Signed branch displacement |
| out_valid | output | 1 | Outputs refreshed by the previous edge |
| result | output | 8 | Operation result |
| dest | output | 2 | 0 none, 1 accumulator, 2 X, 3 operand write-back |
| status_out | output | 8 | Updated status byte |
| br_next | output | 16 | Next program counter |
| br_penalty | output | 2 | Extra branch cycles, 0 to 2 |

## Verification
The flag update and the branch penalty share the same strobe, so one cycle can carry both an arithmetic operation and a taken branch that crosses a page. The bench drives an ADC that overflows together with a branch whose displacement pushes the target into the previous page. It then checks that the result and flags match the arithmetic model and that the next PC and the two-cycle penalty match the page-compare model, with neither path disturbing the other. The rotate and carry chains are probed at their edge values, where a flag taken from the wrong bit would show.

// File: rtl/nmos_alu_pkg.sv
package nmos_alu_pkg;

   typedef enum logic [3:0] {
      OP_LOAD = 4'd0,
      OP_AND  = 4'd1,
      OP_ORA  = 4'd2,
      OP_EOR  = 4'd3,
      OP_ADC  = 4'd4,
      OP_SBC  = 4'd5,
      OP_CMP  = 4'd6,
      OP_CPX  = 4'd7,
      OP_BIT  = 4'd8,
      OP_ASL  = 4'd9,
      OP_LSR  = 4'd10,
      OP_ROL  = 4'd11,
      OP_ROR  = 4'd12,
      OP_AXS  = 4'd13,
      OP_RSV0 = 4'd14,
      OP_RSV1 = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_ACC  = 2'd1,
      DST_XR   = 2'd2,
      DST_OPND = 2'd3
   } alu_dst_e;

   localparam int SB_C = 0;
   localparam int SB_Z = 1;
   localparam int SB_U = 5;
   localparam int SB_V = 6;
   localparam int SB_N = 7;
   localparam logic [7:0] STATUS_RST = 8'h20;

endpackage

// File: rtl/nmos_alu_adder.sv
module nmos_alu_adder #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   logic [W-1:0] b_eff;
   logic [W:0]   full;

   // subtraction uses the ones' complement of b; carry-out is then "no borrow"
   assign b_eff = sub ? ~b : b;
   assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
   assign sum   = full[W-1:0];
   assign cout  = full[W];
   assign ovf   = ~(a[W-1] ^ b_eff[W-1]) & (a[W-1] ^ full[W-1]);
endmodule

// File: rtl/nmos_alu_shifter.sv
module nmos_alu_shifter #(
   parameter int W = 8
) (
   input  logic [W-1:0] val,
   input  logic         left,
   input  logic         rotate,
   input  logic         cin,
   output logic [W-1:0] out,
   output logic         cout
);
   logic fill;
   assign fill = rotate & cin;

   always_comb begin
      if (left) begin
         out  = {val[W-2:0], fill};
         cout = val[W-1];
      end else begin
         out  = {fill, val[W-1:1]};
         cout = val[0];
      end
   end
endmodule

// File: rtl/nmos_branch_calc.sv
module nmos_branch_calc #(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 8,
   parameter int PAGE_W = 8
) (
   input  logic              taken,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] next_pc,
   output logic [1:0]        penalty
);
   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] target;
   logic              crossed;

   assign target  = pc + {{EXT_W{disp[DISP_W-1]}}, disp};
   assign crossed = target[ADDR_W-1:PAGE_W] != pc[ADDR_W-1:PAGE_W];
   assign next_pc = taken ? target : pc;
   assign penalty = !taken ? 2'd0 : (crossed ? 2'd2 : 2'd1);
endmodule

// File: rtl/nmos_alu_core.sv
module nmos_alu_core
   import nmos_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] xr,
   input  logic [DATA_W-1:0] opnd,
   input  logic [7:0]        st_in,
   output logic [DATA_W-1:0] res,
   output alu_dst_e          dst,
   output logic [7:0]        st_out
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] add_a, add_sum, sh_out;
   logic              add_sub, add_cin, add_cout, add_ovf;
   logic              sh_left, sh_rot, sh_cout;
   logic              f_n, f_v, f_z, f_c, upd_nz;
   logic              unused_bit5;

   assign unused_bit5 = st_in[SB_U];

   always_comb begin
      add_a   = acc;
      add_sub = 1'b0;
      add_cin = st_in[SB_C];
      unique case (op)
         OP_SBC:  add_sub = 1'b1;
         OP_CMP:  begin add_sub = 1'b1; add_cin = 1'b1; end
         OP_CPX:  begin add_sub = 1'b1; add_cin = 1'b1; add_a = xr; end
         OP_AXS:  begin add_sub = 1'b1; add_cin = 1'b1; add_a = acc & xr; end
         default: ;
      endcase
   end

   nmos_alu_adder #(.W(DATA_W)) u_adder (
      .a(add_a), .b(opnd), .sub(add_sub), .cin(add_cin),
      .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
   );

   assign sh_left = (op == OP_ASL) || (op == OP_ROL);
   assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

   nmos_alu_shifter #(.W(DATA_W)) u_shift (
      .val(opnd), .left(sh_left), .rotate(sh_rot), .cin(st_in[SB_C]),
      .out(sh_out), .cout(sh_cout)
   );

   always_comb begin
      res    = opnd;
      dst    = DST_NONE;
      upd_nz = 1'b0;
      f_n    = st_in[SB_N];
      f_v    = st_in[SB_V];
      f_z    = st_in[SB_Z];
      f_c    = st_in[SB_C];
      unique case (op)
         OP_LOAD: begin res = opnd;        dst = DST_ACC; upd_nz = 1'b1; end
         OP_AND:  begin res = acc & opnd;  dst = DST_ACC; upd_nz = 1'b1; end
         OP_ORA:  begin res = acc | opnd;  dst = DST_ACC; upd_nz = 1'b1; end
         OP_EOR:  begin res = acc ^ opnd;  dst = DST_ACC; upd_nz = 1'b1; end
         OP_ADC, OP_SBC: begin
            res = add_sum; dst = DST_ACC; upd_nz = 1'b1;
            f_v = add_ovf; f_c = add_cout;
         end
         OP_CMP, OP_CPX: begin
            res = add_sum; upd_nz = 1'b1; f_c = add_cout;
         end
         OP_AXS: begin
            res = add_sum; dst = DST_XR; upd_nz = 1'b1; f_c = add_cout;
         end
         OP_BIT: begin
            res = acc & opnd;
            f_z = (acc & opnd) == '0;
            f_n = opnd[MSB];
            f_v = opnd[MSB-1];
         end
         OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
            res = sh_out; dst = DST_OPND; upd_nz = 1'b1; f_c = sh_cout;
         end
         default: ;
      endcase
      if (upd_nz) begin
         f_z = res == '0;
         f_n = res[MSB];
      end
      st_out = {f_n, f_v, 1'b1, st_in[4:2], f_z, f_c};
   end
endmodule

// File: rtl/nmos_alu_flags.sv
module nmos_alu_flags
   import nmos_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 16,
   parameter int PAGE_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] xreg,
   input  logic [DATA_W-1:0] operand,
   input  logic [7:0]        status_in,
   input  logic              br_taken,
   input  logic [ADDR_W-1:0] br_pc,
   input  logic [DATA_W-1:0] br_disp,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic [1:0]        dest,
   output logic [7:0]        status_out,
   output logic [ADDR_W-1:0] br_next,
   output logic [1:0]        br_penalty
);
   if (DATA_W < 2) begin : g_bad_data_w
      $error("DATA_W must be at least 2");
   end
   if (ADDR_W <= DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must exceed DATA_W");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page_w
      $error("PAGE_W must lie in 1..ADDR_W-1");
   end

   alu_op_e           op_e;
   alu_dst_e          dst_c;
   logic [DATA_W-1:0] res_c;
   logic [7:0]        st_c;
   logic [ADDR_W-1:0] next_c;
   logic [1:0]        pen_c;

   assign op_e = alu_op_e'(op_code);

   nmos_alu_core #(.DATA_W(DATA_W)) u_core (
      .op(op_e), .acc(acc), .xr(xreg), .opnd(operand), .st_in(status_in),
      .res(res_c), .dst(dst_c), .st_out(st_c)
   );

   nmos_branch_calc #(.ADDR_W(ADDR_W), .DISP_W(DATA_W), .PAGE_W(PAGE_W)) u_branch (
      .taken(br_taken), .pc(br_pc), .disp(br_disp),
      .next_pc(next_c), .penalty(pen_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            dest       <= DST_NONE;
            status_out <= STATUS_RST;
            br_next    <= '0;
            br_penalty <= 2'd0;
         end else begin
            out_valid <= op_valid;
            if (op_valid) begin
               result     <= res_c;
               dest       <= dst_c;
               status_out <= st_c;
               br_next    <= next_c;
               br_penalty <= pen_c;
            end
         end
      end

      p_u_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
         status_out[SB_U]);
      p_bit_nv_r4: assert property (@(posedge clk) disable iff (!rst_n)
         op_valid && op_code == OP_BIT |=>
            status_out[SB_N] == $past(operand[DATA_W-1]) &&
            status_out[SB_V] == $past(operand[DATA_W-2]));
      p_logic_vc_r5: assert property (@(posedge clk) disable iff (!rst_n)
         op_valid && op_code inside {OP_LOAD, OP_AND, OP_ORA, OP_EOR} |=>
            status_out[SB_V] == $past(status_in[SB_V]) &&
            status_out[SB_C] == $past(status_in[SB_C]));
      p_cmp_nowr_r3: assert property (@(posedge clk) disable iff (!rst_n)
         op_valid && op_code inside {OP_CMP, OP_CPX} |=> dest == DST_NONE);
      p_nt_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
         op_valid && !br_taken |=> br_penalty == 2'd0 && br_next == $past(br_pc));
      p_pen_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
         br_penalty != 2'd3);
      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !op_valid |=> $stable(result) && $stable(status_out) && !out_valid);
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = op_valid;
      assign result     = res_c;
      assign dest       = dst_c;
      assign status_out = st_c;
      assign br_next    = next_c;
      assign br_penalty = pen_c;
   end
endmodule

// File: tb/nmos_alu_flags_tb.sv
module nmos_alu_flags_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic [7:0]  acc = '0, xreg = '0, operand = '0, status_in = '0, br_disp = '0;
   logic        br_taken = 1'b0;
   logic [15:0] br_pc = '0;
   logic        out_valid;
   logic [7:0]  result, status_out;
   logic [1:0]  dest, br_penalty;
   logic [15:0] br_next;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nmos_alu_flags dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .acc(acc), .xreg(xreg), .operand(operand), .status_in(status_in),
      .br_taken(br_taken), .br_pc(br_pc), .br_disp(br_disp),
      .out_valid(out_valid), .result(result), .dest(dest),
      .status_out(status_out), .br_next(br_next), .br_penalty(br_penalty)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic int sx(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   // independent model written from the requirements
   function automatic void model(input int op, input int a, input int x, input int m,
                                 input int p, output int r, output int dst, output int st);
      int n, v, z, c, cin, t, sv;
      bit nz;
      n = (p >> 7) & 1; v = (p >> 6) & 1; z = (p >> 1) & 1; c = p & 1; cin = c;
      r = 0; dst = 0; nz = 1'b1;
      case (op)
         0: begin r = m; dst = 1; end
         1: begin r = a & m; dst = 1; end
         2: begin r = a | m; dst = 1; end
         3: begin r = a ^ m; dst = 1; end
         4: begin
            t = a + m + cin; r = t & 255; c = int'(t > 255);
            sv = sx(a) + sx(m) + cin; v = int'(sv > 127 || sv < -128); dst = 1;
         end
         5: begin
            t = a - m - (1 - cin); r = t & 255; c = int'(t >= 0);
            sv = sx(a) - sx(m) - (1 - cin); v = int'(sv > 127 || sv < -128); dst = 1;
         end
         6: begin t = a - m; r = t & 255; c = int'(t >= 0); end
         7: begin t = x - m; r = t & 255; c = int'(t >= 0); end
         13: begin t = (a & x) - m; r = t & 255; c = int'(t >= 0); dst = 2; end
         8: begin nz = 1'b0; z = int'((a & m) == 0); n = (m >> 7) & 1; v = (m >> 6) & 1; end
         9: begin r = (m * 2) & 255; c = (m >> 7) & 1; dst = 3; end
         10: begin r = m / 2; c = m & 1; dst = 3; end
         11: begin r = ((m * 2) + cin) & 255; c = (m >> 7) & 1; dst = 3; end
         12: begin r = (m / 2) + cin * 128; c = m & 1; dst = 3; end
         default: nz = 1'b0;
      endcase
      if (nz) begin z = int'(r == 0); n = (r >> 7) & 1; end
      st = n * 128 + v * 64 + 32 + (p & 8'h1C) + z * 2 + c;
   endfunction

   task automatic drive(input int op, input int a, input int x, input int m, input int p,
                        input bit tk, input int pc, input int d);
      @(negedge clk);
      op_code = 4'(op); acc = 8'(a); xreg = 8'(x); operand = 8'(m); status_in = 8'(p);
      br_taken = tk; br_pc = 16'(pc); br_disp = 8'(d); op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic alu_case(input string req, input int op, input int a, input int x,
                           input int m, input int p);
      int r, dst, st;
      drive(op, a, x, m, p, 1'b0, 16'h1234, 0);
      model(op, a, x, m, p, r, dst, st);
      if (dst != 0) chk({req, " result"}, int'(result), r);
      chk({req, " dest"}, int'(dest), dst);
      chk({req, " status"}, int'(status_out), st);
   endtask

   task automatic t_reset;
      chk("R10 reset valid", int'(out_valid), 0);
      chk("R10 reset result", int'(result), 0);
      chk("R10 reset status", int'(status_out), 8'h20);
      chk("R10 reset penalty", int'(br_penalty), 0);
      chk("R10 reset next", int'(br_next), 0);
   endtask

   task automatic t_adc;
      alu_case("R1 adc plain", 4, 8'h10, 0, 8'h20, 8'h00);
      alu_case("R1 adc ovf", 4, 8'h50, 0, 8'h50, 8'h00);
      alu_case("R1 adc carry zero", 4, 8'hFF, 0, 8'h00, 8'h01);
      alu_case("R1 adc neg ovf", 4, 8'h80, 0, 8'hFF, 8'h00);
   endtask

   task automatic t_sbc;
      alu_case("R2 sbc no borrow", 5, 8'h50, 0, 8'h10, 8'h01);
      alu_case("R2 sbc borrow in", 5, 8'h50, 0, 8'h10, 8'h00);
      alu_case("R2 sbc ovf", 5, 8'h50, 0, 8'hB0, 8'h01);
      alu_case("R2 sbc underflow", 5, 8'h00, 0, 8'h01, 8'h01);
   endtask

   task automatic t_compare;
      alu_case("R3 cmp equal", 6, 8'h42, 0, 8'h42, 8'h40);
      alu_case("R3 cmp less", 6, 8'h10, 0, 8'h20, 8'h41);
      alu_case("R3 cpx greater", 7, 8'h00, 8'h90, 8'h10, 8'h00);
      alu_case("R3 axs", 13, 8'hF0, 8'h3C, 8'h05, 8'h40);
      alu_case("R3 axs borrow", 13, 8'h0F, 8'hF0, 8'h01, 8'h01);
   endtask

   task automatic t_bit;
      alu_case("R4 bit zero nv", 8, 8'h01, 0, 8'hC0, 8'h01);
      alu_case("R4 bit nonzero", 8, 8'h3F, 0, 8'h01, 8'hC2);
   endtask

   task automatic t_logic;
      alu_case("R5 and", 1, 8'hF0, 0, 8'h0F, 8'h41);
      alu_case("R5 ora", 2, 8'h80, 0, 8'h01, 8'h00);
      alu_case("R5 eor", 3, 8'hAA, 0, 8'hAA, 8'hC3);
      alu_case("R5 load", 0, 8'h00, 0, 8'h9C, 8'h41);
   endtask

   task automatic t_shift;
      alu_case("R6 asl", 9, 0, 0, 8'h81, 8'h00);
      alu_case("R6 lsr", 10, 0, 0, 8'h01, 8'h80);
      alu_case("R6 lsr n clear", 10, 0, 0, 8'hFE, 8'h81);
   endtask

   task automatic t_rotate;
      alu_case("R7 rol cin", 11, 0, 0, 8'h40, 8'h01);
      alu_case("R7 rol cout", 11, 0, 0, 8'h80, 8'h00);
      alu_case("R7 ror cin", 12, 0, 0, 8'h02, 8'h01);
      alu_case("R7 ror cout", 12, 0, 0, 8'h01, 8'h00);
   endtask

   task automatic t_passthru;
      drive(1, 8'h01, 0, 8'h01, 8'h1C, 1'b0, 0, 0);
      chk("R8 bit5 set and idb pass", int'(status_out), 8'h3C);
      drive(4, 8'h00, 0, 8'h00, 8'h00, 1'b0, 0, 0);
      chk("R8 bit5 from zero status", int'(status_out[5]), 1);
   endtask

   task automatic t_reserved;
      drive(14, 8'h12, 0, 8'h34, 8'hC3, 1'b0, 0, 0);
      chk("R11 rsv14 dest", int'(dest), 0);
      chk("R11 rsv14 status", int'(status_out), 8'hE3);
      drive(15, 8'h00, 0, 8'h00, 8'h00, 1'b0, 0, 0);
      chk("R11 rsv15 status", int'(status_out), 8'h20);
   endtask

   task automatic br_case(input string req, input bit tk, input int pc, input int d);
      int tgt, exp_pen;
      drive(0, 0, 0, 0, 0, tk, pc, d);
      tgt = (pc + sx(d)) & 16'hFFFF;
      exp_pen = !tk ? 0 : (((tgt >> 8) != (pc >> 8)) ? 2 : 1);
      chk({req, " next"}, int'(br_next), tk ? tgt : pc);
      chk({req, " penalty"}, int'(br_penalty), exp_pen);
   endtask

   task automatic t_branch;
      br_case("R9 not taken", 1'b0, 16'h10F0, 8'h20);
      br_case("R9 taken same page", 1'b1, 16'h1010, 8'h20);
      br_case("R9 taken fwd cross", 1'b1, 16'h10F0, 8'h20);
      br_case("R9 taken back cross", 1'b1, 16'h1005, 8'hF0);
      br_case("R9 taken wrap", 1'b1, 16'hFFF0, 8'h7F);
   endtask

   task automatic t_hold;
      drive(4, 8'h01, 0, 8'h02, 8'h00, 1'b1, 16'h2000, 8'h04);
      chk("R10 valid after strobe", int'(out_valid), 1);
      @(negedge clk);
      op_code = 4'd2; acc = 8'hFF; operand = 8'hFF; status_in = 8'hFF;
      br_taken = 1'b1; br_pc = 16'h20F0; br_disp = 8'h7F;
      @(negedge clk);
      chk("R10 valid drops", int'(out_valid), 0);
      chk("R10 hold result", int'(result), 8'h03);
      chk("R10 hold status", int'(status_out), 8'h20);
      chk("R10 hold next", int'(br_next), 16'h2004);
   endtask

   task automatic t_concurrent;
      int r, dst, st;
      drive(4, 8'h7F, 0, 8'h01, 8'h00, 1'b1, 16'h3002, 8'hFA);
      model(4, 8'h7F, 0, 8'h01, 8'h00, r, dst, st);
      chk("R1 concurrent result", int'(result), r);
      chk("R1 concurrent status", int'(status_out), st);
      chk("R9 concurrent next", int'(br_next), 16'h2FFC);
      chk("R9 concurrent penalty", int'(br_penalty), 2);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_adc();
      t_sbc();
      t_compare();
      t_bit();
      t_logic();
      t_shift();
      t_rotate();
      t_passthru();
      t_reserved();
      t_branch();
      t_hold();
      t_concurrent();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule